// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block drives the two timing strobes of a multiplexed external memory bus. One is an active-high address-latch strobe and the other an active-low program-read strobe. The block runs from the oscillator clock. An internal divide-by-two stage splits that clock into two phases per state, and six states make a twelve-clock machine cycle. The instruction decoder reports what kind of machine cycle comes next: a code fetch, an external data move or a code-table read. It also reports whether code is running from external memory. The block samples both at each machine-cycle boundary and plays out the matching strobe pattern over the following twelve clocks.

Software can quiet the latch strobe by setting one control bit through a register write at a fixed address. While the bit is set, the strobe stays at a constant high level in plain code-fetch cycles. It still pulses in data-move and table-read cycles. External execution overrides the bit. A new value of the bit is applied only at the next machine-cycle boundary, so a cycle that has already started is never cut short.

Top module: `bus_strobe_seq`

## Requirements
- R1: While reset is asserted, and for the rest of the partial machine cycle before the first boundary after release (the first 11 clocks, until the 12th rising edge), `ale` is 0 and `psen_n` is 1.
- R2: In a code-fetch cycle with the quiet bit clear, `ale` is 1 in clocks 0, 1, 6 and 7 of the twelve-clock cycle and 0 in the others. That gives two pulses per cycle, each one state wide.
- R3: When `ext_exec` was sampled high for a fetch or table-read cycle, `psen_n` is 0 in clocks 3–5 and 9–11 and 1 in the others, so the read strobe fires twice per cycle.
- R4: When `ext_exec` was sampled low, `psen_n` stays 1 for the whole cycle.
- R5: In an external data-move cycle (`cyc_kind` = 2'b01), the second `ale` pulse (clocks 6–7) is dropped and both `psen_n` activations are skipped.
- R6: With the quiet bit set and `ext_exec` sampled low, a code-fetch cycle holds `ale` at 1 for all twelve clocks.
- R7: With the quiet bit set, data-move and table-read (`cyc_kind` = 2'b10) cycles still produce their normal `ale` pattern.
- R8: With `ext_exec` sampled high, the quiet bit has no effect on `ale`.
- R9: A write with `reg_wr` = 1 and `reg_addr` = 0x8E loads the quiet bit from `reg_wdata` bit 0. The cycle that is running when the write happens keeps its old behaviour, and the new value applies from the next cycle on.
- R10: A register write to any other address leaves the quiet bit unchanged.
- R11: The block samples `cyc_kind` (2'b00 fetch, 2'b01 data move, 2'b10 table read, 2'b11 treated as fetch) and `ext_exec` only at the boundary edge. Changes in the middle of a cycle do not alter that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_kind | input | 2 | Kind of the next machine cycle |
| ext_exec | input | 1 | Code runs from external memory |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write address |
| reg_wdata | input | 8 | Register write data |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-read strobe, active low |

## Verification
A slip in the phase or state counter moves every strobe edge, and `ale` then shows its pulses at the wrong clock offsets within the first cycle after reset. If the sampled cycle kind, external flag or quiet bit is wrong, the error appears as a whole machine cycle with the wrong strobe pattern. A pulse may go missing, an extra read may appear, or the latch strobe may stick high. Such a fault is visible within twelve clocks of the boundary where the bad value was captured. A quiet bit that is applied too early shows up as a changed pattern inside the cycle in which it was written.

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq #(
  parameter logic [7:0] CTRL_ADDR = 8'h8E,
  parameter int         QUIET_BIT = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cyc_kind,
  input  logic       ext_exec,
  input  logic       reg_wr,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic       ale,
  output logic       psen_n
);
  localparam int NST = 6;
  localparam int SW  = $clog2(NST);
  localparam logic [SW-1:0] LAST = SW'(NST - 1);
  localparam logic [SW-1:0] MID  = SW'(NST / 2);

  logic          ph;
  logic [SW-1:0] st;
  logic          live;
  logic [1:0]    kind_q;
  logic          ext_q;
  logic          quiet_q;
  logic          quiet_act;

  wire cyc_end  = ph && (st == LAST);
  wire wr_hit   = reg_wr && (reg_addr == CTRL_ADDR);
  wire quiet_nx = wr_hit ? reg_wdata[QUIET_BIT] : quiet_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= 1'b0;
      st        <= '0;
      live      <= 1'b0;
      kind_q    <= 2'b00;
      ext_q     <= 1'b0;
      quiet_q   <= 1'b0;
      quiet_act <= 1'b0;
    end else begin
      ph      <= ~ph;
      quiet_q <= quiet_nx;
      if (ph) st <= cyc_end ? '0 : st + 1'b1;
      if (cyc_end) begin
        live      <= 1'b1;
        kind_q    <= cyc_kind;
        ext_q     <= ext_exec;
        quiet_act <= quiet_nx;
      end
    end
  end

  wire is_move = (kind_q == 2'b01);
  wire is_tab  = (kind_q == 2'b10);

  wire ale_pat  = (st == '0) || ((st == MID) && !is_move);
  wire ale_hush = quiet_act && !ext_q && !is_move && !is_tab;

  wire rd_win = ((st == SW'(1)) && ph) || (st == SW'(2)) ||
                ((st == MID + SW'(1)) && ph) || (st == MID + SW'(2));

  assign ale    = live && (ale_hush || ale_pat);
  assign psen_n = !(live && ext_q && !is_move && rd_win);
endmodule

module bus_strobe_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ale,
  input logic       psen_n,
  input logic       live,
  input logic       ph,
  input logic [2:0] st,
  input logic [1:0] kind_q,
  input logic       ext_q,
  input logic       quiet_act
);
  always_comb begin
    if (!rst_n) a_r1_reset_idle: assert (!ale && psen_n);
  end

  a_r1_idle_before_first: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> (!ale && psen_n));

  a_r2_ale_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale);

  a_r3_read_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psen_n) |=> !psen_n ##1 !psen_n);

  a_r4_no_read_internal: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !ext_q) |-> psen_n);

  a_r5_no_read_in_move: assert property (@(posedge clk) disable iff (!rst_n)
    (live && kind_q == 2'b01) |-> psen_n);

  a_r9_quiet_held_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph == 1'b0 && st == 3'd0) |-> $stable(quiet_act));

  a_r11_kind_held_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph == 1'b0 && st == 3'd0) |-> ($stable(kind_q) && $stable(ext_q)));
endmodule

bind bus_strobe_seq bus_strobe_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n), .live(live),
  .ph(ph), .st(st), .kind_q(kind_q), .ext_q(ext_q), .quiet_act(quiet_act)
);

// File: tb/tb_bus_strobe_seq.sv
module tb_bus_strobe_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cyc_kind = 2'b00;
  logic       ext_exec = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic       ale;
  logic       psen_n;

  int checks = 0;
  int errors = 0;
  bit quiet_model = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_strobe_seq dut (
    .clk(clk), .rst_n(rst_n), .cyc_kind(cyc_kind), .ext_exec(ext_exec),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ale(ale), .psen_n(psen_n)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic exp_ale(input int k, input logic [1:0] kind, input bit ext, input bit q);
    bit mv = (kind == 2'b01);
    bit tb = (kind == 2'b10);
    if (q && !ext && !mv && !tb) return 1'b1;
    return (k == 0 || k == 1) || ((k == 6 || k == 7) && !mv);
  endfunction

  function automatic logic exp_psen_n(input int k, input logic [1:0] kind, input bit ext);
    bit win = (k >= 3 && k <= 5) || (k >= 9 && k <= 11);
    return !(ext && kind != 2'b01 && win);
  endfunction

  // Runs one machine cycle; called with the design at clock 11 of the previous cycle.
  task automatic run_cyc(input logic [1:0] kind, input bit ext, input bit do_wr,
                         input logic [7:0] waddr, input logic [7:0] wdat,
                         input bit jiggle, input string req);
    bit q = quiet_model;
    cyc_kind = kind;
    ext_exec = ext;
    for (int k = 0; k < 12; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(req, $sformatf("ale clk%0d", k), ale, exp_ale(k, kind, ext, q));
      chk(req, $sformatf("psen_n clk%0d", k), psen_n, exp_psen_n(k, kind, ext));
      if (k == 4 && do_wr) begin
        reg_wr = 1'b1; reg_addr = waddr; reg_wdata = wdat;
      end else begin
        reg_wr = 1'b0;
      end
      if (k == 5 && jiggle) begin
        cyc_kind = ~kind;
        ext_exec = ~ext;
      end
    end
    if (do_wr && waddr == 8'h8E) quiet_model = wdat[0];
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1", "ale in reset", ale, 1'b0);
    chk("R1", "psen_n in reset", psen_n, 1'b1);
    cyc_kind = 2'b00; ext_exec = 1'b1;
    rst_n = 1'b1;
    for (int k = 1; k < 12; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R1", $sformatf("ale before first cycle clk%0d", k), ale, 1'b0);
      chk("R1", $sformatf("psen_n before first cycle clk%0d", k), psen_n, 1'b1);
    end
  endtask

  task automatic t_fetch;
    run_cyc(2'b00, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, "R2 R4");
    run_cyc(2'b00, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, "R2 R3");
    run_cyc(2'b11, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, "R11 code3");
    run_cyc(2'b10, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, "R3 table");
  endtask

  task automatic t_move;
    run_cyc(2'b01, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, "R5 ext");
    run_cyc(2'b01, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, "R5 int");
  endtask

  task automatic t_quiet;
    run_cyc(2'b00, 1'b0, 1'b1, 8'h8E, 8'h01, 1'b0, "R9 write cycle");
    run_cyc(2'b00, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, "R6 R9");
    run_cyc(2'b01, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, "R7 move");
    run_cyc(2'b10, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, "R7 table");
    run_cyc(2'b00, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, "R8");
  endtask

  task automatic t_other_addr;
    run_cyc(2'b00, 1'b0, 1'b1, 8'h8F, 8'h00, 1'b0, "R10 write");
    run_cyc(2'b00, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, "R10 still quiet");
  endtask

  task automatic t_clear;
    run_cyc(2'b00, 1'b0, 1'b1, 8'h8E, 8'hFE, 1'b0, "R9 clear write");
    run_cyc(2'b00, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, "R9 cleared");
  endtask

  task automatic t_midcycle;
    run_cyc(2'b00, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, "R11 jiggle fetch");
    run_cyc(2'b01, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, "R11 jiggle move");
  endtask

  initial begin
    t_reset;
    t_fetch;
    t_move;
    t_quiet;
    t_other_addr;
    t_clear;
    t_midcycle;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule